// File: doc/BRIEF.md
# Receive DMA bus request generator

This block decides when the receive DMA engine asks for the system bus, and with what priority. It watches the free-byte count of the receive FIFO. When enough data has collected to make a burst worth while, it raises a normal request. When the FIFO is close to overflow, it raises an urgent request instead. The urgent request ignores the burst-size rule and outranks every other requester at the arbiter.

The urgent level comes from an 8-bit host register. Its low five bits give the level in 32-byte units, and its upper three bits are reserved. The burst level is an input in bytes. All request outputs are combinational from the current FIFO count and settings. A request therefore rises or falls in the same cycle that the free space crosses a level.

Top module: `rxdma_req_gen`

## Requirements
- R1: After reset, the register reads back 0x04, so the urgent level is 4 units (128 bytes).
- R2: A write with `reg_we_i` high stores `reg_wdata_i[4:0]` as the urgent level. The new value appears on `reg_rdata_o[4:0]` and in the urgent compare from the next cycle. With no write, the level holds.
- R3: `reg_rdata_o[7:5]` always reads 0. A write to those bits has no effect on the read-back value or on the urgent level.
- R4: `req_urg_o` is high while `fifo_free_i` is strictly below the level times 32. It is low when the free count equals that product.
- R5: `req_urg_o` falls in the same cycle that `fifo_free_i` rises to or above the level times 32. No cycle of delay is added.
- R6: A level of 0 keeps `req_urg_o` low for every free count, including 0.
- R7: The buffered count is `FIFO_BYTES - fifo_free_i`, taken as 0 when the free count is at or above `FIFO_BYTES`. The normal condition is true when the buffered count is nonzero and at or above `burst_thresh_i`. `req_norm_o` equals the normal condition while no urgent request is active.
- R8: An urgent request is raised even when the buffered count is below `burst_thresh_i`.
- R9: While an urgent request is active, `urg_prio_o` is high and `req_norm_o` is low. The two request outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_free_i | input | CNT_W (12) | Free bytes in the receive FIFO |
| burst_thresh_i | input | CNT_W (12) | Buffered bytes needed for a normal request |
| reg_we_i | input | 1 | Write strobe for the urgent level register |
| reg_wdata_i | input | 8 | Write data for the register |
| reg_rdata_o | output | 8 | Register read-back value |
| req_norm_o | output | 1 | Normal bus request |
| req_urg_o | output | 1 | Urgent bus request |
| urg_prio_o | output | 1 | Top-priority flag for the arbiter |

## Verification
The bench drives the free count to exactly the level times 32 and to one below it. A design that compares with "at or below" fails there. The bench also steps upward across the level in back-to-back cycles, and a design that registers the compare stays urgent one cycle too long. A level of 0 is tested with the FIFO completely full, where a wrapped or non-strict compare would fire. Further cases are an all-ones write that would expose stored reserved bits, an urgent request while the buffered count is below the burst level, and a normal request that must stay low at the same time as an urgent one.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int REG_W     = 8;
  localparam int THR_W     = 5;
  localparam int UNIT_LOG2 = 5;  // 32-byte units
  localparam logic [THR_W-1:0] THR_RST = 5'd4;
endpackage

// File: rtl/rxu_thr_reg.sv
module rxu_thr_reg
  import rxdma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [THR_W-1:0] thr_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   thr_q <= THR_RST;
    else if (we_i) thr_q <= wdata_i[THR_W-1:0];
  end

  assign thr_o   = thr_q;
  assign rdata_o = {{(REG_W-THR_W){1'b0}}, thr_q};

  // R2
  p_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[THR_W-1:0] == $past(wdata_i[THR_W-1:0]));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(thr_o));
endmodule

// File: rtl/rxu_urgent.sv
module rxu_urgent
  import rxdma_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] free_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             urg_o
);
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = CNT_W'(thr_i) << UNIT_LOG2;
    urg_o = free_i < limit;  // strict: zero level never fires
  end
endmodule

// File: rtl/rxu_burst.sv
module rxu_burst #(
  parameter int FIFO_BYTES = 2048,
  parameter int CNT_W      = 12
) (
  input  logic [CNT_W-1:0] free_i,
  input  logic [CNT_W-1:0] burst_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(FIFO_BYTES);
  logic [CNT_W-1:0] used;

  always_comb begin
    used  = (free_i >= DEPTH) ? '0 : DEPTH - free_i;
    hit_o = (used != '0) && (used >= burst_i);
  end
endmodule

// File: rtl/rxdma_req_gen.sv
module rxdma_req_gen
  import rxdma_pkg::*;
#(
  parameter  int FIFO_BYTES = 2048,
  localparam int CNT_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fifo_free_i,
  input  logic [CNT_W-1:0] burst_thresh_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             req_norm_o,
  output logic             req_urg_o,
  output logic             urg_prio_o
);
  logic [THR_W-1:0] thr;
  logic             urg, hit;

  rxu_thr_reg u_reg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .thr_o(thr), .rdata_o(reg_rdata_o)
  );

  rxu_urgent #(.CNT_W(CNT_W)) u_urg (
    .free_i(fifo_free_i), .thr_i(thr), .urg_o(urg)
  );

  rxu_burst #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) u_burst (
    .free_i(fifo_free_i), .burst_i(burst_thresh_i), .hit_o(hit)
  );

  // urgent wins over the burst rule
  assign req_urg_o  = urg;
  assign urg_prio_o = urg;
  assign req_norm_o = hit & ~urg;

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_norm_o, req_urg_o}));
  p_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_urg_o |-> urg_prio_o);
  p_zero_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o == '0) |-> !req_urg_o);
  p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urg && !hit) |-> req_urg_o);
  p_norm_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_norm_o |-> (fifo_free_i < CNT_W'(FIFO_BYTES)));
endmodule

// File: tb/sim_rxdma_req_gen.sv
module sim_rxdma_req_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;
  localparam int CW = 12;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] free = CW'(DEPTH), burst = '0;
  logic we = 0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic norm, urg, prio;

  int checks = 0, errors = 0;
  int thr_m = 4;
  string tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdma_req_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_free_i(free), .burst_thresh_i(burst),
    .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .req_norm_o(norm), .req_urg_o(urg), .urg_prio_o(prio)
  );

  // reference register model
  always @(posedge clk or negedge rst_n)
    if (!rst_n) thr_m <= 4;
    else if (we) thr_m <= int'(wd) % 32;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle away from the edge
  always @(negedge clk) if (!done) begin
    int used, e_urg, e_hit;
    used  = (int'(free) >= DEPTH) ? 0 : DEPTH - int'(free);
    e_urg = (int'(free) < thr_m * 32) ? 1 : 0;
    e_hit = (used > 0 && used >= int'(burst)) ? 1 : 0;
    chk("rdata R2 R3", int'(rdata), thr_m);
    if (rst_n) begin
      chk("urgent R4 R5 R6 R8", int'(urg), e_urg);
      chk("normal R7", int'(norm), (e_hit && !e_urg) ? 1 : 0);
      chk("prio R9", int'(prio), e_urg);
    end
  end

  task automatic step(input int f, input int b, input bit w, input int d);
    free = CW'(f); burst = CW'(b); we = w; wd = 8'(d);
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset value
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R4 boundary at default level 128 bytes
    tag = "R4";
    step(127, 0, 0, 0);
    step(128, 0, 0, 0);
    step(0, 0, 0, 0);
    // R3 all-ones write: reserved bits must drop
    tag = "R3";
    step(DEPTH, 0, 1, 'hFF);
    step(DEPTH, 0, 0, 0);
    // R2 new level 10 units = 320 bytes
    tag = "R2";
    step(DEPTH, 0, 1, 'hEA);
    step(319, 0, 0, 0);
    // R5 free rises across level in consecutive cycles
    tag = "R5";
    step(320, 0, 0, 0);
    step(319, 0, 0, 0);
    step(1000, 0, 0, 0);
    // R8 urgent while buffered below burst level
    tag = "R8";
    step(100, 2000, 0, 0);
    step(319, 2040, 0, 0);
    // R7 burst boundary with no urgency
    tag = "R7";
    step(DEPTH - 64, 64, 0, 0);
    step(DEPTH - 63, 64, 0, 0);
    step(DEPTH, 0, 0, 0);
    step(DEPTH - 1, 0, 0, 0);
    // R9 both conditions true: urgent must win
    tag = "R9";
    step(10, 5, 0, 0);
    // R6 zero level, full FIFO
    tag = "R6";
    step(DEPTH, 0, 1, 'hE0);
    step(0, 0, 0, 0);
    step(1, 4, 0, 0);
    // mixed traffic
    tag = "R4";
    for (int i = 0; i < 400; i++) begin
      int f, b, w;
      f = int'($urandom_range(0, DEPTH + 10));
      b = int'($urandom_range(0, DEPTH));
      w = ($urandom_range(0, 9) == 0) ? 1 : 0;
      step(f, b, w[0], int'($urandom_range(0, 255)));
    end
    @(negedge clk); #1;
    finish_run();
  end
endmodule